// File: doc/BRIEF.md
# Strap-Addressed Serial Register Bank Slave

This block is a two-wire serial bus slave that gives a bus master access to a small bank of 8-bit control registers. Its 7-bit bus address has a fixed upper part. The two lowest bits come from two strap pins, so that up to four copies can share one bus. The first byte the master sends after the address byte is a register pointer. Data bytes that follow are stored from that pointer onward, and the pointer steps by one after every byte.

To read, the master first sets the pointer with a write-addressed transfer. It then issues a repeated START and sends the address with the read bit set. The slave returns one register per byte and keeps going while the master acknowledges. A not-acknowledge from the master ends the output, and the slave then waits for STOP. SCL and SDA are sampled through two-flop synchronisers on the system clock. SDA is driven open-drain through an output enable. The whole register bank is presented in parallel for the surrounding logic to use.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 1,1,0,0,0 followed by the level of `strap_a2` and then the level of `strap_a1`. The last bit of the address byte is R/W, with 0 meaning write and 1 meaning read. An acknowledge is SDA held low during the ninth SCL clock.
- R2: When the address does not match, the slave gives no acknowledge and keeps SDA released. It ignores every later byte, and no register changes, until the next START or STOP.
- R3: After a matched write address, the slave acknowledges the pointer byte and every data byte. Each data byte is stored in the register the pointer selects, and the pointer then steps by one.
- R4: The pointer takes the low 4 bits of the pointer byte. It steps from 15 back to 0, both in write bursts and in read bursts.
- R5: Every byte moves most significant bit first, in both directions.
- R6: After a repeated START with a matched address and R/W=1, the slave acknowledges and returns the register at the current pointer as the first byte.
- R7: In a read, a master acknowledge (SDA low on the ninth clock) causes the next register to be returned. A master not-acknowledge (SDA high) ends the output, and SDA stays released until STOP or START.
- R8: The slave changes SDA only while SCL is low, so each read bit is stable for the whole SCL high phase.
- R9: STOP returns the slave to idle, and bytes clocked after it without a START are ignored and not acknowledged. A START in the middle of a byte discards that partial byte and restarts address reception.
- R10: After reset all registers read 0x00 and SDA is released.
- R11: A burst of 0x0E, 0xD8, 0xE1 from pointer 0x00 leaves registers 0, 1 and 2 holding those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock level from the bus |
| sda_in | input | 1 | Serial data level from the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_a2 | input | 1 | Strap for address bit 1 |
| strap_a1 | input | 1 | Strap for address bit 0 |
| regs_flat | output | NUM_REGS*8 | Register r sits on bits [8r+7:8r] |

## Verification
Every bus edge passes two synchroniser flops and one edge register before the slave reacts. A register write therefore lands about three system clocks after the SCL rise of the eighth data bit. The acknowledge drive and each new read bit appear about three clocks after an SCL fall. The bench holds each SCL phase for twelve clocks. It samples acknowledges and read bits in the middle of the SCL high phase, and samples them again just before the fall to confirm they stayed stable. The reference register model updates only at the end of each transaction. The per-clock comparison against the register outputs therefore runs only between transactions, when the delay no longer matters.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WR,
    ST_RD,
    ST_RDEND,
    ST_IGN
  } bus_state_t;

  // Full 7-bit bus address: fixed prefix followed by the two strap levels.
  function automatic logic [6:0] own_address(logic [4:0] prefix, logic strap_hi, logic strap_lo);
    return {prefix, strap_hi, strap_lo};
  endfunction

  // Serial bytes arrive MSB first: append the new bit at the bottom.
  function automatic logic [7:0] shift_in(logic [7:0] cur, logic b);
    return {cur[6:0], b};
  endfunction

  // Open-drain enable for read bit number idx (0 = MSB).
  function automatic logic tx_low(logic [7:0] data, logic [3:0] idx);
    return ~data[3'd7 - idx[2:0]];
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_prev  <= 1'b1;
      sda_prev  <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_in};
      sda_chain <= {sda_chain[STAGES-2:0], sda_in};
      scl_prev  <= scl_chain[STAGES-1];
      sda_prev  <= sda_chain[STAGES-1];
    end
  end

  assign scl_lvl   = scl_chain[STAGES-1];
  assign sda_lvl   = sda_chain[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
  parameter int NUM_REGS = 16,
  parameter int PTR_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_ptr,
  input  logic [7:0]            wr_data,
  input  logic [PTR_W-1:0]      rd_ptr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  logic [7:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   regs_q[g] <= 8'h00;
      else if (wr_en && wr_ptr == PTR_W'(g))        regs_q[g] <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = regs_q[g];

    // A write strobe aimed at this register leaves the byte there one cycle later.
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ptr == PTR_W'(g)) |=> (regs_q[g] == $past(wr_data)));
  end

  // Pointer values with no register behind them read as zero.
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_ptr == PTR_W'(i)) rd_data = regs_q[i];
    end
  end

endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
  import i2c_rb_pkg::*;
#(
  parameter int         PTR_W      = 4,
  parameter logic [4:0] DEV_PREFIX = 5'b11000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             strap_a2,
  input  logic             strap_a1,
  input  logic [7:0]       rd_data,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [7:0]       wr_data,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             sda_oe
);

  bus_state_t       state_q;
  logic [3:0]       cnt_q;      // 0..7 data bits, 8 = acknowledge clock
  logic [7:0]       shreg_q;
  logic [7:0]       txbyte_q;
  logic [PTR_W-1:0] ptr_q;
  logic             ack_go_q;   // slave owns the coming acknowledge slot
  logic             oe_q;

  // Named internal events
  logic [7:0] byte_in;
  logic       byte_end;
  logic       rx_phase;
  logic       ack_clock;
  logic       addr_hit;

  assign byte_in   = shift_in(shreg_q, sda_lvl);
  assign byte_end  = scl_rise && (cnt_q == 4'd7);
  assign ack_clock = scl_rise && (cnt_q == 4'd8);
  assign rx_phase  = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WR);
  assign addr_hit  = (byte_in[7:1] == own_address(DEV_PREFIX, strap_a2, strap_a1));

  assign wr_en   = byte_end && (state_q == ST_WR);
  assign wr_ptr  = ptr_q;
  assign wr_data = byte_in;
  assign rd_ptr  = ptr_q;
  assign sda_oe  = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= 4'd0;
      shreg_q  <= 8'h00;
      txbyte_q <= 8'h00;
      ptr_q    <= '0;
      ack_go_q <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start_evt) begin
      state_q  <= ST_ADDR;
      cnt_q    <= 4'd0;
      ack_go_q <= 1'b0;
      oe_q     <= 1'b0;
    end else if (stop_evt) begin
      state_q  <= ST_IDLE;
      cnt_q    <= 4'd0;
      ack_go_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (scl_rise && (rx_phase || state_q == ST_RD)) begin
        if (ack_clock) begin
          cnt_q <= 4'd0;
          if (ack_go_q) begin
            ack_go_q <= 1'b0;
          end else if (state_q == ST_RD) begin
            if (!sda_lvl) txbyte_q <= rd_data;   // master wants more
            else          state_q  <= ST_RDEND;  // master is done
          end
        end else begin
          cnt_q <= cnt_q + 4'd1;
          if (rx_phase) shreg_q <= byte_in;
          if (byte_end) begin
            unique case (state_q)
              ST_ADDR: begin
                if (addr_hit) begin
                  ack_go_q <= 1'b1;
                  if (byte_in[0]) begin
                    state_q  <= ST_RD;
                    txbyte_q <= rd_data;
                  end else begin
                    state_q  <= ST_PTR;
                  end
                end else begin
                  state_q <= ST_IGN;
                end
              end
              ST_PTR: begin
                ptr_q    <= byte_in[PTR_W-1:0];
                ack_go_q <= 1'b1;
                state_q  <= ST_WR;
              end
              ST_WR: begin
                ptr_q    <= ptr_q + 1'b1;
                ack_go_q <= 1'b1;
              end
              ST_RD:   ptr_q <= ptr_q + 1'b1;
              default: ;
            endcase
          end
        end
      end

      if (scl_fall) begin
        if (cnt_q == 4'd8 && ack_go_q)          oe_q <= 1'b1;
        else if (state_q == ST_RD && cnt_q < 4'd8) oe_q <= tx_low(txbyte_q, cnt_q);
        else                                     oe_q <= 1'b0;
      end
    end
  end

  // SDA drive changes only while the synchronised SCL is low.
  assert_oe_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !scl_lvl);

  // A foreign address leaves the line untouched.
  assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGN) |-> !oe_q);

  // After the master declines more data the line stays released.
  assert_nack_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDEND) |-> !oe_q);

  // A data byte completes while the slave has the line released.
  assert_wr_bus_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !oe_q);

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int         NUM_REGS    = 16,
  parameter int         PTR_W       = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] DEV_PREFIX  = 5'b11000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  input  logic                  strap_a2,
  input  logic                  strap_a1,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [7:0]       wr_data, rd_data;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_rb_engine #(.PTR_W(PTR_W), .DEV_PREFIX(DEV_PREFIX)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .strap_a2  (strap_a2),
    .strap_a1  (strap_a1),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .rd_ptr    (rd_ptr),
    .sda_oe    (sda_oe)
  );

  i2c_rb_regfile #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .rd_ptr    (rd_ptr),
    .rd_data   (rd_data),
    .regs_flat (regs_flat)
  );

endmodule

// File: tb/i2c_regbank_slave_bench.sv
`timescale 1ns/1ps
module i2c_regbank_slave_bench;

  localparam int HALF = 12;   // system clocks per SCL phase
  localparam int Q    = 4;    // data setup point inside a low phase

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic st2 = 1'b1, st1 = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [127:0] regs_flat;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;
  logic [7:0] model [16];
  logic [7:0] byte_q [$];

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_regbank_slave u_i2c_regbank_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .strap_a2(st2), .strap_a1(st1), .regs_flat(regs_flat)
  );

  function automatic logic [6:0] dev_of(logic a2, logic a1);
    return {5'b11000, a2, a1};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference register image compared on every clock between transactions (R3, R10).
  always @(negedge clk) begin
    if (rst_n && cmp_en && !done) begin
      for (int r = 0; r < 16; r++) begin
        if (regs_flat[r*8 +: 8] !== model[r])
          chk(1'b0, "R3", $sformatf("reg %0d image", r), regs_flat[r*8 +: 8], model[r]);
      end
      checks++;
    end
  end

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wait_h(Q); sda_m = 1'b1;
    wait_h(HALF); scl_m = 1'b1;
    wait_h(HALF); sda_m = 1'b0;
    wait_h(HALF); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_h(Q); sda_m = 1'b0;
    wait_h(HALF); scl_m = 1'b1;
    wait_h(HALF); sda_m = 1'b1;
    wait_h(HALF);
  endtask

  task automatic tx_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wait_h(Q); sda_m = b[i];
      wait_h(HALF - Q); scl_m = 1'b1;
      wait_h(HALF); scl_m = 1'b0;
    end
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit acked);
    tx_bits(b, 8);
    wait_h(Q); sda_m = 1'b1;
    wait_h(HALF - Q); scl_m = 1'b1;
    wait_h(HALF / 2); acked = !sda_bus;
    wait_h(HALF / 2); scl_m = 1'b0;
  endtask

  task automatic rx_byte(input bit master_ack, output logic [7:0] b);
    logic s1, s2;
    wait_h(Q); sda_m = 1'b1;
    wait_h(HALF - Q);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b1;
      wait_h(HALF / 2); s1 = sda_bus;
      wait_h(HALF / 2 - 1); s2 = sda_bus;
      wait_h(1); scl_m = 1'b0;
      chk(s1 == s2, "R8", "read bit stable while SCL high", int'(s2), int'(s1));
      b[i] = s1;
      if (i > 0) wait_h(HALF);
    end
    wait_h(Q); sda_m = master_ack ? 1'b0 : 1'b1;
    wait_h(HALF - Q); scl_m = 1'b1;
    wait_h(HALF); scl_m = 1'b0;
    wait_h(Q); sda_m = 1'b1;
    wait_h(HALF - Q);
  endtask

  task automatic wr_burst(input logic [6:0] dev, input logic [7:0] ptr, input bit expect_ack, input string req);
    bit a;
    int p;
    cmp_en = 1'b0;
    bus_start();
    tx_byte({dev, 1'b0}, a);
    chk(a == expect_ack, req, "address acknowledge", int'(a), int'(expect_ack));
    tx_byte(ptr, a);
    chk(a == expect_ack, req, "pointer acknowledge", int'(a), int'(expect_ack));
    foreach (byte_q[k]) begin
      tx_byte(byte_q[k], a);
      chk(a == expect_ack, req, "data acknowledge", int'(a), int'(expect_ack));
    end
    bus_stop();
    if (expect_ack) begin
      p = int'(ptr[3:0]);
      foreach (byte_q[k]) begin
        model[p] = byte_q[k];
        p = (p + 1) % 16;
      end
    end
    cmp_en = 1'b1;
    wait_h(HALF);
  endtask

  task automatic rd_burst(input logic [6:0] dev, input logic [7:0] ptr, input int n);
    bit a;
    logic [7:0] b;
    int p;
    cmp_en = 1'b0;
    bus_start();
    tx_byte({dev, 1'b0}, a);
    tx_byte(ptr, a);
    bus_start();
    tx_byte({dev, 1'b1}, a);
    chk(a == 1'b1, "R6", "read address acknowledge", int'(a), 1);
    p = int'(ptr[3:0]);
    for (int i = 0; i < n; i++) begin
      rx_byte(i < n - 1, b);
      chk(b == model[p], (i == 0) ? "R5 R6" : "R7 R4", $sformatf("read byte %0d", i), b, model[p]);
      p = (p + 1) % 16;
    end
    for (int i = 0; i < 4; i++) begin
      wait_h(3);
      chk(sda_oe == 1'b0, "R7", "line released after not-acknowledge", int'(sda_oe), 0);
    end
    bus_stop();
    cmp_en = 1'b1;
    wait_h(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    for (int r = 0; r < 16; r++) model[r] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(regs_flat == '0, "R10", "registers after reset", int'(regs_flat[31:0]), 0);
    chk(sda_oe == 1'b0, "R10", "SDA released after reset", int'(sda_oe), 0);
    cmp_en = 1'b1;
    wait_h(HALF);

    // R11 R3 R1: three-byte burst from pointer 0
    byte_q = {8'h0E, 8'hD8, 8'hE1};
    wr_burst(dev_of(st2, st1), 8'h00, 1'b1, "R1 R3");
    chk(regs_flat[7:0]   == 8'h0E, "R11", "reg 0", regs_flat[7:0],   8'h0E);
    chk(regs_flat[15:8]  == 8'hD8, "R11", "reg 1", regs_flat[15:8],  8'hD8);
    chk(regs_flat[23:16] == 8'hE1, "R11", "reg 2", regs_flat[23:16], 8'hE1);

    // R6 R7 R5: read back three with ACK, ACK, NACK
    rd_burst(dev_of(st2, st1), 8'h00, 3);

    // R2: foreign address, bytes must be ignored
    byte_q = {8'hFF, 8'h55};
    wr_burst(dev_of(~st2, st1), 8'h00, 1'b0, "R2");
    chk(regs_flat[7:0] == 8'h0E, "R2", "reg 0 untouched", regs_flat[7:0], 8'h0E);

    // R4: write burst wraps 15 -> 0, read burst wraps too
    byte_q = {8'hA5, 8'h5A, 8'h3C};
    wr_burst(dev_of(st2, st1), 8'hFE, 1'b1, "R3 R4");
    chk(regs_flat[7:0] == 8'h3C, "R4", "wrapped write lands in reg 0", regs_flat[7:0], 8'h3C);
    rd_burst(dev_of(st2, st1), 8'h0F, 2);

    // R9: START in the middle of a byte restarts address reception
    cmp_en = 1'b0;
    bus_start();
    tx_byte({dev_of(st2, st1), 1'b0}, a);
    tx_byte(8'h05, a);
    tx_bits(8'hAA, 4);
    bus_start();
    tx_byte({dev_of(st2, st1), 1'b0}, a);
    chk(a == 1'b1, "R9", "address after restart acknowledged", int'(a), 1);
    tx_byte(8'h06, a);
    tx_byte(8'h77, a);
    bus_stop();
    model[6] = 8'h77;
    cmp_en = 1'b1;
    wait_h(HALF);
    chk(regs_flat[47:40] == 8'h00, "R9", "partial byte discarded (reg 5)", regs_flat[47:40], 0);
    chk(regs_flat[55:48] == 8'h77, "R9", "reg 6 after restart", regs_flat[55:48], 8'h77);

    // R9: after STOP, a byte without START is ignored
    scl_m = 1'b0;
    tx_byte({dev_of(st2, st1), 1'b0}, a);
    chk(a == 1'b0, "R9", "no acknowledge without START", int'(a), 0);
    wait_h(Q); scl_m = 1'b1;
    wait_h(HALF);

    // R1: new strap levels move the address
    st2 = 1'b0; st1 = 1'b1;
    wait_h(HALF);
    byte_q = {8'h81};
    wr_burst(7'b1100010, 8'h09, 1'b0, "R1");
    wr_burst(7'b1100001, 8'h09, 1'b1, "R1");
    chk(regs_flat[79:72] == 8'h81, "R1", "reg 9 via new address", regs_flat[79:72], 8'h81);
    rd_burst(7'b1100001, 8'h09, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule